// File: doc/BRIEF.md
# Soft-Stop Duty Ramp Sequencer

This block sets the duty-cycle ceiling of a forward-converter PWM modulator. When the enable input is high and no fault is flagged, it starts from zero. It raises the ceiling by one LSB after every fixed number of clocks until the ceiling reaches full scale, and then holds it there. When a shutdown is requested, the block does one of two things. With the stop-style input at 0 it lowers the ceiling at the same rate, so that synchronous rectifiers do not pull the output negative. With that input at 1 it drops the ceiling to zero at once.

A shutdown request is enable going low or the input-undervoltage flag going high. Once a controlled ramp-down has started, it runs until the ceiling falls below a low threshold, even if the request goes away first. A supply-UVLO flag overrides everything and clears the ceiling in one clock. The done output pulses when a controlled ramp-down finishes. From the off state, a new start always ramps up again from zero.

Top module: `pwm_softstop_seq`

## Requirements
- R1: After reset, duty_lim_o is 0 and running_o and done_o are low.
- R2: When enable_i is 1 and uv_flag_i and uvlo_i are 0 in the idle or off state, the ceiling starts at 0 and rises by exactly one LSB every STEP_CLKS clocks until it reaches 2^RAMP_W-1. It then holds that value without wrapping, and running_o stays high.
- R3: With mode_i at 0, a shutdown request (enable_i at 0, or uv_flag_i at 1) during ramp-up or at full scale starts a ramp-down. The ramp-down begins from the value held when the request arrived and falls by one LSB every STEP_CLKS clocks.
- R4: Once a ramp-down has started, changes on enable_i, uv_flag_i and mode_i are ignored, and the ramp-down continues until the ceiling is below STOP_LEVEL.
- R5: One clock after the ceiling falls below STOP_LEVEL during a ramp-down, duty_lim_o is 0, running_o is low and done_o is high for exactly that one clock.
- R6: With mode_i at 1, a shutdown request during ramp-up or at full scale clears duty_lim_o to 0 on the next clock, and done_o stays low.
- R7: uvlo_i at 1 clears duty_lim_o and running_o on the next clock in any state and under either mode, including during a ramp-down, and done_o stays low. No start happens while uvlo_i is 1.
- R8: A start from the off state always begins a fresh ramp-up from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 0 selects controlled ramp-down, 1 selects immediate stop |
| enable_i | input | 1 | Run request; a falling level asks for shutdown |
| uv_flag_i | input | 1 | Input-undervoltage comparator flag, 1 = fault |
| uvlo_i | input | 1 | Supply undervoltage lockout, 1 = fault |
| duty_lim_o | output | RAMP_W | Duty-cycle ceiling for the modulator |
| running_o | output | 1 | High while ramping up, at full scale or ramping down |
| done_o | output | 1 | One-clock pulse when a ramp-down completes |

## Verification
The bench aims at the turnaround points of the ramp. A design that restarts its step timer wrongly, or that steps at the moment of a request, shows an off-by-one in the first value or in the step spacing after the change of direction. In one run the undervoltage fault is removed and enable is raised again in the middle of a ramp-down. A design that does not commit to the ramp-down would then climb back up at that point instead of first finishing at the threshold. Further runs cover supply lockout during a ramp-down, which must not give a done pulse, and a hard stop under mode 1. They also cover restart after off, which must start from zero, and the threshold edge itself, where the last value seen must be STOP_LEVEL-1.

// File: rtl/softstop_pkg.sv
package softstop_pkg;
   typedef enum logic [2:0] {
      SEQ_IDLE = 3'd0,
      SEQ_UP   = 3'd1,
      SEQ_FULL = 3'd2,
      SEQ_DOWN = 3'd3,
      SEQ_OFF  = 3'd4
   } seq_state_e;
endpackage

// File: rtl/softstop_tick.sv
module softstop_tick #(
   parameter int STEP_CLKS = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic clr_i,
   output logic tick_o
);
   if (STEP_CLKS < 1) begin : g_bad_step
      $error("softstop_tick: STEP_CLKS must be at least 1");
   end

   if (STEP_CLKS == 1) begin : g_every_clk
      assign tick_o = run_i && !clr_i;
   end else begin : g_counter
      localparam int CW = $clog2(STEP_CLKS);
      localparam logic [CW-1:0] LAST = CW'(STEP_CLKS - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                cnt_q <= '0;
         else if (clr_i || !run_i)  cnt_q <= '0;
         else if (cnt_q == LAST)    cnt_q <= '0;
         else                       cnt_q <= cnt_q + 1'b1;
      end

      assign tick_o = run_i && !clr_i && (cnt_q == LAST);

      // R2
      cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_q <= LAST);
   end
endmodule

// File: rtl/softstop_ramp.sv
module softstop_ramp #(
   parameter int RAMP_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              inc_i,
   input  logic              dec_i,
   output logic [RAMP_W-1:0] val_o
);
   localparam logic [RAMP_W-1:0] TOP = '1;
   logic [RAMP_W-1:0] val_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      val_q <= '0;
      else if (clr_i)  val_q <= '0;
      else if (inc_i)  val_q <= val_q + 1'b1;
      else if (dec_i)  val_q <= val_q - 1'b1;
   end

   assign val_o = val_q;

   // R2
   no_wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inc_i |-> val_q != TOP);
   // R3
   no_wrap_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_i |-> val_q != '0);
   // R2
   single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !inc_i && !dec_i) |=> $stable(val_q));
endmodule

// File: rtl/softstop_fsm.sv
module softstop_fsm
   import softstop_pkg::*;
#(
   parameter int RAMP_W     = 10,
   parameter int STOP_LEVEL = 51
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_i,
   input  logic              en_i,
   input  logic              uv_i,
   input  logic              uvlo_i,
   input  logic              tick_i,
   input  logic [RAMP_W-1:0] val_i,
   output seq_state_e        state_o,
   output logic              inc_o,
   output logic              dec_o,
   output logic              clr_o,
   output logic              chg_o,
   output logic              done_o
);
   localparam logic [RAMP_W-1:0] TOP   = '1;
   localparam logic [RAMP_W-1:0] FLOOR = RAMP_W'(STOP_LEVEL);

   seq_state_e state_q, nxt;
   logic       done_q;
   logic       stop_req, go_ok;

   assign stop_req = !en_i || uv_i;
   assign go_ok    = en_i && !uv_i;

   always_comb begin
      nxt = state_q;
      if (uvlo_i) begin
         nxt = (state_q == SEQ_IDLE) ? SEQ_IDLE : SEQ_OFF;
      end else begin
         case (state_q)
            SEQ_IDLE, SEQ_OFF: if (go_ok) nxt = SEQ_UP;
            SEQ_UP: begin
               if (stop_req)          nxt = mode_i ? SEQ_OFF : SEQ_DOWN;
               else if (val_i == TOP) nxt = SEQ_FULL;
            end
            SEQ_FULL: if (stop_req) nxt = mode_i ? SEQ_OFF : SEQ_DOWN;
            SEQ_DOWN: if (val_i < FLOOR) nxt = SEQ_OFF;
            default:  nxt = SEQ_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         done_q  <= 1'b0;
      end else begin
         state_q <= nxt;
         done_q  <= (state_q == SEQ_DOWN) && (nxt == SEQ_OFF) && !uvlo_i;
      end
   end

   assign state_o = state_q;
   assign chg_o   = (nxt != state_q);
   assign clr_o   = (nxt == SEQ_OFF) || (nxt == SEQ_IDLE) ||
                    ((nxt == SEQ_UP) && (state_q != SEQ_UP));
   assign inc_o   = (state_q == SEQ_UP)   && (nxt == SEQ_UP)   && tick_i;
   assign dec_o   = (state_q == SEQ_DOWN) && (nxt == SEQ_DOWN) && tick_i;
   assign done_o  = done_q;

   // R4
   commit_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SEQ_DOWN && !uvlo_i && val_i >= FLOOR) |=> state_q == SEQ_DOWN);
   // R5
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   // R7
   no_start_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uvlo_i |=> (state_q == SEQ_OFF || state_q == SEQ_IDLE));
endmodule

// File: rtl/pwm_softstop_seq.sv
module pwm_softstop_seq
   import softstop_pkg::*;
#(
   parameter int RAMP_W     = 10,
   parameter int STEP_CLKS  = 64,
   parameter int STOP_LEVEL = 51
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_i,
   input  logic              enable_i,
   input  logic              uv_flag_i,
   input  logic              uvlo_i,
   output logic [RAMP_W-1:0] duty_lim_o,
   output logic              running_o,
   output logic              done_o
);
   localparam int FULL = (1 << RAMP_W) - 1;

   if (RAMP_W < 2 || RAMP_W > 16) begin : g_bad_width
      $error("pwm_softstop_seq: RAMP_W out of range 2..16");
   end
   if (STOP_LEVEL < 1 || STOP_LEVEL >= FULL) begin : g_bad_level
      $error("pwm_softstop_seq: STOP_LEVEL must lie in 1..full scale-1");
   end

   seq_state_e        state;
   logic              tick, inc, dec, clr, chg, ramping;
   logic [RAMP_W-1:0] ramp;

   assign ramping = (state == SEQ_UP) || (state == SEQ_DOWN);

   softstop_tick #(.STEP_CLKS(STEP_CLKS)) tick_i (
      .clk(clk), .rst_n(rst_n), .run_i(ramping), .clr_i(chg), .tick_o(tick));

   softstop_ramp #(.RAMP_W(RAMP_W)) ramp_i (
      .clk(clk), .rst_n(rst_n), .clr_i(clr), .inc_i(inc), .dec_i(dec),
      .val_o(ramp));

   softstop_fsm #(.RAMP_W(RAMP_W), .STOP_LEVEL(STOP_LEVEL)) fsm_i (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .en_i(enable_i),
      .uv_i(uv_flag_i), .uvlo_i(uvlo_i), .tick_i(tick), .val_i(ramp),
      .state_o(state), .inc_o(inc), .dec_o(dec), .clr_o(clr), .chg_o(chg),
      .done_o(done_o));

   assign duty_lim_o = ramp;
   assign running_o  = (state == SEQ_UP) || (state == SEQ_FULL) || (state == SEQ_DOWN);

   // R7
   uvlo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uvlo_i |=> (duty_lim_o == '0 && !running_o && !done_o));
   // R6
   hard_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i && !uvlo_i && (state == SEQ_UP || state == SEQ_FULL) &&
       (!enable_i || uv_flag_i)) |=> (duty_lim_o == '0 && !done_o));
   // R5
   done_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (duty_lim_o == '0 && !running_o));
endmodule

// File: tb/pwm_softstop_seq_tb_top.sv
module pwm_softstop_seq_tb_top;
   localparam int RW   = 8;
   localparam int STEP = 3;
   localparam int LVL  = 13;
   localparam int TOPV = (1 << RW) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode = 1'b0, en = 1'b0, uv = 1'b0, uvlo = 1'b0;
   logic [RW-1:0] duty;
   logic running, done;

   int checks = 0;
   int errors = 0;
   int done_cnt = 0;
   int cyc = 0;
   bit finished = 0;
   logic [RW-1:0] exp_q[$];

   always #10 clk = ~clk;

   pwm_softstop_seq #(.RAMP_W(RW), .STEP_CLKS(STEP), .STOP_LEVEL(LVL)) dut_i (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .enable_i(en),
      .uv_flag_i(uv), .uvlo_i(uvlo), .duty_lim_o(duty),
      .running_o(running), .done_o(done));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic push_range(input int from, input int to);
      if (from <= to) for (int v = from; v <= to; v++) exp_q.push_back(RW'(v));
      else            for (int v = from; v >= to; v--) exp_q.push_back(RW'(v));
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: pops expected values as the ceiling changes
   initial begin : monitor
      logic [RW-1:0] prev;
      int last_cyc, last_dir, dir, diff;
      bit prev_done;
      prev = '0; last_cyc = 0; last_dir = 0; prev_done = 0;
      forever begin
         @(negedge clk);
         cyc++;
         if (rst_n) begin
            if (duty != prev) begin
               if (exp_q.size() == 0) begin
                  chk(0, "R2/R3 unexpected change", int'(duty), -1);
               end else begin
                  logic [RW-1:0] e;
                  e = exp_q.pop_front();
                  chk(duty == e, "R2/R3/R8 ramp value", int'(duty), int'(e));
               end
               diff = int'(duty) - int'(prev);
               dir = (diff == 1) ? 1 : (diff == -1) ? -1 : 0;
               if (dir != 0 && dir == last_dir)
                  chk(cyc - last_cyc == STEP, "R2/R3 step spacing", cyc - last_cyc, STEP);
               last_dir = dir;
               last_cyc = cyc;
            end
            if (done) begin
               done_cnt++;
               chk(duty == 0, "R5 duty at done", int'(duty), 0);
               chk(int'(prev) == LVL - 1, "R5 last value before done", int'(prev), LVL - 1);
               chk(!prev_done, "R5 done width", 2, 1);
            end
            prev = duty;
            prev_done = done;
         end
      end
   end

   // watchdog
   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         chk(0, "watchdog expired", cyc, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   // driver
   initial begin : driver
      cycles(3);
      // R1
      chk(duty == 0, "R1 reset duty", int'(duty), 0);
      chk(!running, "R1 reset running", int'(running), 0);
      chk(!done, "R1 reset done", int'(done), 0);
      rst_n = 1'b1;
      cycles(5);
      chk(duty == 0 && !running, "R1 idle without enable", int'(duty), 0);

      // R2: ramp up and hold at full scale
      push_range(1, TOPV);
      en = 1'b1;
      wait (duty == RW'(TOPV));
      cycles(10 * STEP);
      chk(duty == RW'(TOPV), "R2 hold at full scale", int'(duty), TOPV);
      chk(running, "R2 running at full scale", int'(running), 1);

      // R3, R5: controlled ramp-down via enable
      push_range(TOPV - 1, LVL - 1);
      exp_q.push_back('0);
      en = 1'b0;
      wait (done_cnt == 1);
      cycles(4);
      chk(duty == 0, "R5 off after ramp-down", int'(duty), 0);
      chk(!running, "R5 running low after ramp-down", int'(running), 0);

      // R3, R4, R8: stop mid ramp-up via uv, fault clears mid ramp-down
      push_range(1, 100);
      en = 1'b1;
      wait (duty == RW'(100));
      @(negedge clk);
      push_range(99, LVL - 1);
      exp_q.push_back('0);
      push_range(1, TOPV);
      uv = 1'b1;
      wait (duty == RW'(60));
      @(negedge clk);
      uv = 1'b0;
      mode = 1'b1;
      cycles(2 * STEP);
      mode = 1'b0;
      // R4
      chk(running && duty < RW'(60), "R4 ramp-down continues", int'(duty), 59);
      wait (duty == RW'(TOPV));
      @(negedge clk);
      chk(done_cnt == 2, "R8 restart after done", done_cnt, 2);

      // R6: hard stop in mode 1
      mode = 1'b1;
      exp_q.push_back('0);
      en = 1'b0;
      cycles(2);
      chk(duty == 0, "R6 hard stop duty", int'(duty), 0);
      chk(!running, "R6 hard stop running", int'(running), 0);
      chk(done_cnt == 2, "R6 no done pulse", done_cnt, 2);
      mode = 1'b0;

      // R7: lockout at full scale, no start while locked
      push_range(1, TOPV);
      en = 1'b1;
      wait (duty == RW'(TOPV));
      @(negedge clk);
      exp_q.push_back('0);
      uvlo = 1'b1;
      cycles(1);
      chk(duty == 0 && !running, "R7 lockout clears", int'(duty), 0);
      cycles(20);
      chk(duty == 0 && !running, "R7 no start under lockout", int'(duty), 0);
      push_range(1, TOPV);
      uvlo = 1'b0;
      wait (duty == RW'(TOPV));
      @(negedge clk);

      // R7: lockout during ramp-down gives no done
      push_range(TOPV - 1, 150);
      exp_q.push_back('0);
      en = 1'b0;
      wait (duty == RW'(150));
      @(negedge clk);
      uvlo = 1'b1;
      cycles(2);
      chk(duty == 0 && !running, "R7 lockout in ramp-down", int'(duty), 0);
      uvlo = 1'b0;
      cycles(5 * STEP);
      chk(done_cnt == 2, "R7 no done on lockout", done_cnt, 2);
      chk(duty == 0, "R7 stays off without enable", int'(duty), 0);
      chk(exp_q.size() == 0, "R2/R3 all expected values seen", exp_q.size(), 0);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule